// File: doc/BRIEF.md
# Locked Control Register Bank

This block is a byte-wide register file for a clock-buffer control path. It sits behind a plain management port that has an address, write data, a write strobe and read data. A bus engine elsewhere turns serial transactions into single-cycle strobes on this port. The file holds these fields:

- per-output enables and side-band masks
- per-output slew selections, which point into a table of four programmable slew values
- a global amplitude code
- input configuration bits
- a programmable block-read byte count

Each output's selection is resolved through the slew table, and the block drives the resulting per-output slew code directly.

Two independent locks protect the control fields. The first lock is sticky until a power-on reset. The second lock flips each time a 1 is written to it. A loss-of-signal detector input sets a sticky event flag, and software clears that flag by writing a 1 to it. The lock bits and the event clear stay writable while a lock is active, so software can always release the clearable lock and acknowledge events. Fixed identification bytes, a registered copy of the side-band disable state, and a live loss readback are read-only.

Top module: `ctl_regfile_lock`

## Requirements
- R1: After reset the following values read back, and `slew_code` is 0xAAAA:
  - 0x00 reads 0x0F
  - 0x01 reads 0x00
  - 0x02 reads 0xAA
  - 0x03 reads 0x60
  - 0x04 reads 0xFA
  - 0x07 reads 0x07
  - 0x08 reads 0x10
  - 0x11 reads 0x60
  - 0x26 reads 0x00
  - 0x27 reads 0x00
- R2: Offset 0x05 reads 0x0A (revision 0 in bits 7:4, vendor 0xA in bits 3:0). Offset 0x06 reads 0x04. Writes to either offset have no effect.
- R3: While unlocked, the control fields take the written data on the clock edge with the strobe high. The control fields are:
  - 0x00 bits 3:0: output enables, also driven on `out_en`
  - 0x01 bits 3:0: side-band masks
  - 0x02: slew selections, 2 bits per output with output i at bits 2i+1:2i
  - 0x03 and 0x04: slew table entries 0..3, two 4-bit entries per byte with the lower entry in the low nibble
  - 0x08: bit 0 AC-coupled input, bit 1 termination, bit 4 automatic disable enable
  - 0x11 bits 7:4: amplitude code

  Reserved bits and unlisted offsets read 0 and ignore writes.
- R4: Offset 0x07 bits 4:0 hold the block-read byte count. The field is writable and bits 7:5 read 0.
- R5: Writing 1 to bit 0 of 0x26 sets the permanent lock.
  - The lock blocks every control-field write and raises `wr_locked`.
  - Writing 0 to the bit does not clear it; only reset clears it.
- R6: Writing 1 to bit 0 of 0x27 toggles the clearable lock, and writing 0 to the bit leaves it unchanged. While this lock is set, control-field writes are blocked.
- R7: Bit 1 of 0x27 is set on any clock edge where `los_det` is high. It stays set until a 1 is written to it. Writing 0 to the bit has no effect.
- R8: If a clear of the loss flag and a high `los_det` occur in the same cycle, the flag remains set.
- R9: Offsets 0x26 and 0x27 remain writable while either lock is active.
- R10: Side-band disable readback is registered from `sbd_in`, resets to all ones, and is read-only. It reads at two offsets:
  - 0x0B: bit 0 = output 2, bit 1 = output 3
  - 0x0C: bit 0 = output 0, bit 1 = output 1
- R11: `slew_code[4i+3:4i]` equals the slew table entry that output i's 2-bit selection picks.
- R12: Offset 0x12 bit 0 reads the live inverse of `los_det` and is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| addr | input | 8 | Register offset |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Combinational read data for `addr` |
| los_det | input | 1 | Loss-of-signal detector output, high on loss |
| sbd_in | input | 4 | Side-band disable state per output |
| out_en | output | 4 | Output enables |
| sb_mask | output | 4 | Side-band disable masks |
| slew_code | output | 16 | Resolved 4-bit slew code per output |
| amp_code | output | 4 | Amplitude code |
| byte_count | output | 5 | Block-read byte count |
| in_ac | output | 1 | AC-coupled input bias enable |
| in_term | output | 1 | Input termination enable |
| aod_en | output | 1 | Automatic output disable enable |
| wr_locked | output | 1 | High while either lock is set |

## Verification
A loss detection and a software clear of the same flag can land on one clock edge. The bench provokes this by raising `los_det` in the same cycle as a write of 0x02 to 0x27, and then judges that the flag still reads set. A lock toggle and an event clear can also share one write. A write of 0x03 to 0x27, made with the clearable lock and the flag both set, must drop both bits together. A following control write is then checked to take effect.

// File: rtl/ctl_regfile_lock.sv
module ctl_regfile_lock #(
  parameter logic [3:0] REV_CODE    = 4'h0,
  parameter logic [3:0] VENDOR_CODE = 4'hA,
  parameter logic [7:0] DEVICE_CODE = 8'h04,
  parameter logic [4:0] BC_RESET    = 5'd7,
  parameter logic [3:0] AMP_RESET   = 4'h6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  output logic [7:0]  rdata,
  input  logic        los_det,
  input  logic [3:0]  sbd_in,
  output logic [3:0]  out_en,
  output logic [3:0]  sb_mask,
  output logic [15:0] slew_code,
  output logic [3:0]  amp_code,
  output logic [4:0]  byte_count,
  output logic        in_ac,
  output logic        in_term,
  output logic        aod_en,
  output logic        wr_locked
);
  localparam logic [7:0] A_EN    = 8'h00;
  localparam logic [7:0] A_MASK  = 8'h01;
  localparam logic [7:0] A_SEL   = 8'h02;
  localparam logic [7:0] A_OPTLO = 8'h03;
  localparam logic [7:0] A_OPTHI = 8'h04;
  localparam logic [7:0] A_ID0   = 8'h05;
  localparam logic [7:0] A_ID1   = 8'h06;
  localparam logic [7:0] A_BC    = 8'h07;
  localparam logic [7:0] A_CFG   = 8'h08;
  localparam logic [7:0] A_SBHI  = 8'h0B;
  localparam logic [7:0] A_SBLO  = 8'h0C;
  localparam logic [7:0] A_AMP   = 8'h11;
  localparam logic [7:0] A_LIVE  = 8'h12;
  localparam logic [7:0] A_PLOCK = 8'h26;
  localparam logic [7:0] A_TLOCK = 8'h27;
  localparam int         NOUT    = 4;

  logic [3:0] en_q, mask_q, amp_q, sbd_q;
  logic [7:0] sel_q;
  logic [3:0] opt_q [4];
  logic [4:0] bc_q;
  logic       ac_q, term_q, aod_q;
  logic       perm_lock, tog_lock, los_flag;

  logic locked, cw, los_clr;
  assign locked  = perm_lock | tog_lock;
  assign cw      = wr_en & ~locked;
  assign los_clr = wr_en & (addr == A_TLOCK) & wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= 4'hF;
      mask_q   <= 4'h0;
      sel_q    <= 8'hAA;
      opt_q[0] <= 4'h0;
      opt_q[1] <= 4'h6;
      opt_q[2] <= 4'hA;
      opt_q[3] <= 4'hF;
      bc_q     <= BC_RESET;
      amp_q    <= AMP_RESET;
      ac_q     <= 1'b0;
      term_q   <= 1'b0;
      aod_q    <= 1'b1;
    end else if (cw) begin
      case (addr)
        A_EN:    en_q   <= wdata[3:0];
        A_MASK:  mask_q <= wdata[3:0];
        A_SEL:   sel_q  <= wdata;
        A_OPTLO: begin opt_q[0] <= wdata[3:0]; opt_q[1] <= wdata[7:4]; end
        A_OPTHI: begin opt_q[2] <= wdata[3:0]; opt_q[3] <= wdata[7:4]; end
        A_BC:    bc_q   <= wdata[4:0];
        A_CFG:   begin ac_q <= wdata[0]; term_q <= wdata[1]; aod_q <= wdata[4]; end
        A_AMP:   amp_q  <= wdata[7:4];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      perm_lock <= 1'b0;
      tog_lock  <= 1'b0;
      los_flag  <= 1'b0;
      sbd_q     <= 4'hF;
    end else begin
      sbd_q <= sbd_in;
      if (wr_en && addr == A_PLOCK && wdata[0]) perm_lock <= 1'b1;
      if (wr_en && addr == A_TLOCK && wdata[0]) tog_lock  <= ~tog_lock;
      los_flag <= los_det | (los_flag & ~los_clr);
    end
  end

  for (genvar g = 0; g < NOUT; g++) begin : g_slew
    assign slew_code[4*g +: 4] = opt_q[sel_q[2*g +: 2]];
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = {4'h0, en_q};
      A_MASK:  rdata = {4'h0, mask_q};
      A_SEL:   rdata = sel_q;
      A_OPTLO: rdata = {opt_q[1], opt_q[0]};
      A_OPTHI: rdata = {opt_q[3], opt_q[2]};
      A_ID0:   rdata = {REV_CODE, VENDOR_CODE};
      A_ID1:   rdata = DEVICE_CODE;
      A_BC:    rdata = {3'b000, bc_q};
      A_CFG:   rdata = {3'b000, aod_q, 2'b00, term_q, ac_q};
      A_SBHI:  rdata = {6'h00, sbd_q[3], sbd_q[2]};
      A_SBLO:  rdata = {6'h00, sbd_q[1], sbd_q[0]};
      A_AMP:   rdata = {amp_q, 4'h0};
      A_LIVE:  rdata = {7'h00, ~los_det};
      A_PLOCK: rdata = {7'h00, perm_lock};
      A_TLOCK: rdata = {6'h00, los_flag, tog_lock};
      default: rdata = 8'h00;
    endcase
  end

  assign out_en     = en_q;
  assign sb_mask    = mask_q;
  assign amp_code   = amp_q;
  assign byte_count = bc_q;
  assign in_ac      = ac_q;
  assign in_term    = term_q;
  assign aod_en     = aod_q;
  assign wr_locked  = locked;
endmodule

module ctl_regfile_lock_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] addr,
  input logic [7:0] wdata,
  input logic       wr_en,
  input logic [7:0] rdata,
  input logic       los_det,
  input logic [3:0] out_en,
  input logic       wr_locked,
  input logic       perm_lock,
  input logic       tog_lock,
  input logic       los_flag
);
  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    perm_lock |=> perm_lock); // R5
  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_locked && wr_en && addr == 8'h00) |=> $stable(out_en)); // R6
  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 8'h27 && wdata[0]) |=> (tog_lock != $past(tog_lock))); // R9
  AST_LOS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    los_det |=> los_flag); // R8
  AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h06) |-> (rdata == 8'h04)); // R2
  AST_BC_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'h07) |-> (rdata[7:5] == 3'b000)); // R4
endmodule

bind ctl_regfile_lock ctl_regfile_lock_chk u_chk (.*);

// File: tb/test_ctl_regfile_lock.sv
`timescale 1ns/1ps
module test_ctl_regfile_lock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic wr_en = 1'b0, los_det = 1'b0;
  logic [3:0] sbd_in = 4'hF;
  logic [3:0] out_en, sb_mask, amp_code;
  logic [15:0] slew_code;
  logic [4:0] byte_count;
  logic in_ac, in_term, aod_en, wr_locked;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ctl_regfile_lock i_ctl_regfile_lock (.*);

  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {8'h00, 8'hFF, 8'h0F}, {8'h00, 8'h05, 8'h05}, {8'h01, 8'hFA, 8'h0A},
    {8'h02, 8'h1B, 8'h1B}, {8'h03, 8'h5C, 8'h5C}, {8'h04, 8'h93, 8'h93},
    {8'h07, 8'hFF, 8'h1F}, {8'h07, 8'h12, 8'h12}, {8'h11, 8'h9F, 8'h90},
    {8'h08, 8'hFF, 8'h13}, {8'h05, 8'hFF, 8'h0A}, {8'h06, 8'h00, 8'h04},
    {8'h40, 8'hFF, 8'h00}, {8'h0B, 8'h00, 8'h03}, {8'h12, 8'hFF, 8'h01}
  };
  localparam int VTAG [NV] = '{3, 3, 3, 3, 3, 3, 4, 4, 3, 3, 2, 2, 3, 10, 12};

  function automatic string rq(int n);
    case (n)
      2: return "R2";
      3: return "R3";
      4: return "R4";
      10: return "R10";
      12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(string r, logic [7:0] a, logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(r, {24'h0, rdata}, {24'h0, exp});
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd("R1", 8'h00, 8'h0F); rd("R1", 8'h01, 8'h00); rd("R1", 8'h02, 8'hAA);
    rd("R1", 8'h03, 8'h60); rd("R1", 8'h04, 8'hFA); rd("R1", 8'h07, 8'h07);
    rd("R1", 8'h08, 8'h10); rd("R1", 8'h11, 8'h60); rd("R1", 8'h26, 8'h00);
    rd("R1", 8'h27, 8'h00);
    chk("R1", {16'h0, slew_code}, 32'h0000AAAA);
    rd("R10", 8'h0C, 8'h03);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][23:16], VEC[i][15:8]);
      rd(rq(VTAG[i]), VEC[i][23:16], VEC[i][7:0]);
    end
    chk("R3", {28'h0, out_en}, 32'h5);
    chk("R3", {28'h0, sb_mask}, 32'hA);
    chk("R3", {29'h0, aod_en, in_term, in_ac}, 32'h7);
    chk("R4", {27'h0, byte_count}, 32'h12);
    chk("R11", {16'h0, slew_code}, 32'h0000C539);

    // R10 registered, read-only readback
    @(negedge clk); sbd_in = 4'b0101;
    repeat (2) @(negedge clk);
    rd("R10", 8'h0C, 8'h01); rd("R10", 8'h0B, 8'h01);
    wr(8'h0C, 8'hFF); rd("R10", 8'h0C, 8'h01);

    // R7 sticky loss flag, R12 live readback
    @(negedge clk); los_det = 1'b1; addr = 8'h12; #1;
    chk("R12", {24'h0, rdata}, 32'h00);
    @(negedge clk); los_det = 1'b0;
    rd("R7", 8'h27, 8'h02);
    wr(8'h27, 8'h00); rd("R7", 8'h27, 8'h02);
    wr(8'h27, 8'h02); rd("R7", 8'h27, 8'h00);
    wr(8'h12, 8'h00); rd("R12", 8'h12, 8'h01);

    // R8 event and clear in the same cycle
    @(negedge clk); addr = 8'h27; wdata = 8'h02; wr_en = 1'b1; los_det = 1'b1;
    @(negedge clk); wr_en = 1'b0; los_det = 1'b0;
    rd("R8", 8'h27, 8'h02);

    // R6 clearable lock toggles
    wr(8'h27, 8'h01); rd("R6", 8'h27, 8'h03);
    chk("R6", {31'h0, wr_locked}, 32'h1);
    wr(8'h00, 8'h0F); rd("R6", 8'h00, 8'h05);
    wr(8'h27, 8'h00); rd("R6", 8'h27, 8'h03);
    // R9 lock toggle and flag clear in one write while locked
    wr(8'h27, 8'h03); rd("R9", 8'h27, 8'h00);
    wr(8'h00, 8'h0C); rd("R6", 8'h00, 8'h0C);

    // R5 permanent lock
    wr(8'h26, 8'h01); rd("R5", 8'h26, 8'h01);
    chk("R5", {31'h0, wr_locked}, 32'h1);
    wr(8'h00, 8'h03); rd("R5", 8'h00, 8'h0C);
    wr(8'h26, 8'h00); rd("R5", 8'h26, 8'h01);
    wr(8'h27, 8'h01); rd("R9", 8'h27, 8'h01);
    wr(8'h27, 8'h01); rd("R9", 8'h27, 8'h00);
    wr(8'h11, 8'hF0); rd("R5", 8'h11, 8'h90);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd("R5", 8'h26, 8'h00); rd("R1", 8'h00, 8'h0F);
    chk("R5", {31'h0, wr_locked}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule